// File: doc/BRIEF.md
# Memory-to-Memory Add Sequencer

This block is the control sequencer for one fixed operation: it reads two byte operands from memory, adds them and writes the sum back to memory. A start pulse supplies three memory addresses: the first operand, the second operand and the result. The sequencer then walks a fixed ten-step list of register transfers. It drives the memory address register and the memory data register, raises fetch and store requests, moves data between the memory data register and three general registers (first operand, second operand, sum), and issues one add command. A one-cycle done pulse marks the end of the run.

The memory side uses a request/acknowledge scheme. A fetch or store request stays high, with a steady address and write data, until the memory answers with a one-cycle done. Every step that does not wait for memory takes exactly one clock. This makes the length of a run a fixed function of the memory latency. The general registers keep their values after a run, so a host can observe them.

Top module: `mm_add_sequencer`

## Requirements
- R1: After reset all three general registers read 0, `busy_o`, `done_o`, `alu_add_o`, `mem_fetch_o` and `mem_store_o` are low, and a reset in the middle of a run clears the general registers again.
- R2: The first memory access of a run is a fetch at the first-operand address, and the byte it returns appears on `r1_o`.
- R3: The second access is a fetch at the second-operand address, and the byte it returns appears on `r2_o`.
- R4: `alu_add_o` is high for exactly one cycle per run, and in the next cycle `r3_o` equals `(r1_o + r2_o) mod 256`.
- R5: The third and last access of a run is a store at the result address whose write data equals the sum on `r3_o`. A run makes exactly three accesses.
- R6: A fetch or store request stays high, with a stable address and write data, until `mem_done_i` is sampled high. When every access is acknowledged in its L-th request cycle, `done_o` is first seen 8 + 3L falling edges after the edge on which `start_i` is driven, and the fetch and store requests are high for 2L and L cycles.
- R7: The three addresses are captured in the cycle that accepts `start_i`. Later changes on the address inputs do not affect the run.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored: it neither changes the accesses or the result nor starts a second run.
- R9: `done_o` is high for exactly one cycle, after which `busy_o` is low and a new `start_i` is accepted.
- R10: `mem_fetch_o` and `mem_store_o` are never high together, and neither is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| x_addr_i | input | AW | First-operand address |
| y_addr_i | input | AW | Second-operand address |
| w_addr_i | input | AW | Result address |
| mem_addr_o | output | AW | Memory address register contents |
| mem_wdata_o | output | DW | Memory data register contents (store data) |
| mem_rdata_i | input | DW | Read data, valid with `mem_done_i` on a fetch |
| mem_fetch_o | output | 1 | Fetch request, held until acknowledged |
| mem_store_o | output | 1 | Store request, held until acknowledged |
| mem_done_i | input | 1 | One-cycle acknowledge from memory |
| alu_add_o | output | 1 | Add command, one cycle per run |
| r1_o | output | DW | First-operand general register |
| r2_o | output | DW | Second-operand general register |
| r3_o | output | DW | Sum general register |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The add is exercised with a small in-range sum, with a sum that wraps past 255, with the same address used for both operands, and with the result address equal to the first-operand address. Together these separate a correct add from one that swaps or reuses an operand, and show whether the write-back uses the sum or a stale register. The addresses include 0x00 and 0xFF. The memory latency is varied between 1, 2 and 3 cycles, so the run length and the request-held counts show whether a step waits for the acknowledge or skips it. One run scrambles the address inputs right after start and fires a second start with other addresses in the middle of the run. Any leak of those addresses shows up as a fourth access or a wrong sum.

// File: rtl/addseq_pkg.sv
`timescale 1ns/1ps
package addseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_MAR_X    = 4'd1,
        ST_FETCH_X  = 4'd2,
        ST_LOAD_R1  = 4'd3,
        ST_MAR_Y    = 4'd4,
        ST_FETCH_Y  = 4'd5,
        ST_LOAD_R2  = 4'd6,
        ST_ADD      = 4'd7,
        ST_SUM_MDR  = 4'd8,
        ST_MAR_W    = 4'd9,
        ST_STORE    = 4'd10,
        ST_DONE     = 4'd11
    } step_e;

    typedef enum logic [1:0] {
        MAR_KEEP   = 2'd0,
        MAR_FROM_X = 2'd1,
        MAR_FROM_Y = 2'd2,
        MAR_FROM_W = 2'd3
    } mar_src_e;

    typedef struct packed {
        logic     capture;
        mar_src_e mar_src;
        logic     mdr_from_mem;
        logic     mdr_from_sum;
        logic     r1_load;
        logic     r2_load;
        logic     sum_load;
        logic     fetch;
        logic     store;
        logic     done;
        logic     busy;
    } ctl_t;

endpackage

// File: rtl/addseq_ctrl.sv
`timescale 1ns/1ps
module addseq_ctrl
    import addseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mem_done_i,
    output ctl_t ctl_o
);

    typedef struct packed {
        step_e step;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    ctl_t        ctl_d;

    always_comb begin
        st_d  = st_q;
        ctl_d = '0;
        case (st_q.step)
            ST_IDLE: begin
                ctl_d.capture = start_i;
                if (start_i) st_d.step = ST_MAR_X;
            end
            ST_MAR_X: begin
                ctl_d.mar_src = MAR_FROM_X;
                st_d.step     = ST_FETCH_X;
            end
            ST_FETCH_X: begin
                ctl_d.fetch        = 1'b1;
                ctl_d.mdr_from_mem = mem_done_i;
                if (mem_done_i) st_d.step = ST_LOAD_R1;
            end
            ST_LOAD_R1: begin
                ctl_d.r1_load = 1'b1;
                st_d.step     = ST_MAR_Y;
            end
            ST_MAR_Y: begin
                ctl_d.mar_src = MAR_FROM_Y;
                st_d.step     = ST_FETCH_Y;
            end
            ST_FETCH_Y: begin
                ctl_d.fetch        = 1'b1;
                ctl_d.mdr_from_mem = mem_done_i;
                if (mem_done_i) st_d.step = ST_LOAD_R2;
            end
            ST_LOAD_R2: begin
                ctl_d.r2_load = 1'b1;
                st_d.step     = ST_ADD;
            end
            ST_ADD: begin
                ctl_d.sum_load = 1'b1;
                st_d.step      = ST_SUM_MDR;
            end
            ST_SUM_MDR: begin
                ctl_d.mdr_from_sum = 1'b1;
                st_d.step          = ST_MAR_W;
            end
            ST_MAR_W: begin
                ctl_d.mar_src = MAR_FROM_W;
                st_d.step     = ST_STORE;
            end
            ST_STORE: begin
                ctl_d.store = 1'b1;
                if (mem_done_i) st_d.step = ST_DONE;
            end
            ST_DONE: begin
                ctl_d.done = 1'b1;
                st_d.step  = ST_IDLE;
            end
            default: st_d.step = ST_IDLE;
        endcase
        ctl_d.busy = (st_q.step != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/addseq_addr.sv
`timescale 1ns/1ps
module addseq_addr
    import addseq_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  mar_src_e      mar_src_i,
    input  logic [AW-1:0] x_addr_i,
    input  logic [AW-1:0] y_addr_i,
    input  logic [AW-1:0] w_addr_i,
    output logic [AW-1:0] mar_o
);

    localparam int unsigned NPTR = 3;

    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] ptr;
        logic [AW-1:0]           mar;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.ptr[0] = x_addr_i;
            st_d.ptr[1] = y_addr_i;
            st_d.ptr[2] = w_addr_i;
        end
        case (mar_src_i)
            MAR_FROM_X: st_d.mar = st_q.ptr[0];
            MAR_FROM_Y: st_d.mar = st_q.ptr[1];
            MAR_FROM_W: st_d.mar = st_q.ptr[2];
            default:    st_d.mar = st_q.mar;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mar_o = st_q.mar;

endmodule

// File: rtl/addseq_regs.sv
`timescale 1ns/1ps
module addseq_regs #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdr_from_mem_i,
    input  logic          mdr_from_sum_i,
    input  logic          r1_load_i,
    input  logic          r2_load_i,
    input  logic          sum_load_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [DW-1:0] mdr_o,
    output logic [DW-1:0] r1_o,
    output logic [DW-1:0] r2_o,
    output logic [DW-1:0] r3_o
);

    typedef struct packed {
        logic [DW-1:0] mdr;
        logic [DW-1:0] r1;
        logic [DW-1:0] r2;
        logic [DW-1:0] r3;
    } regs_state_t;

    regs_state_t   st_d, st_q;
    logic [DW-1:0] sum;

    always_comb begin
        sum  = st_q.r1 + st_q.r2;
        st_d = st_q;
        if (mdr_from_mem_i)      st_d.mdr = mem_rdata_i;
        else if (mdr_from_sum_i) st_d.mdr = st_q.r3;
        if (r1_load_i)  st_d.r1 = st_q.mdr;
        if (r2_load_i)  st_d.r2 = st_q.mdr;
        if (sum_load_i) st_d.r3 = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdr_o = st_q.mdr;
    assign r1_o  = st_q.r1;
    assign r2_o  = st_q.r2;
    assign r3_o  = st_q.r3;

endmodule

// File: rtl/mm_add_sequencer.sv
`timescale 1ns/1ps
module mm_add_sequencer
    import addseq_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] x_addr_i,
    input  logic [AW-1:0] y_addr_i,
    input  logic [AW-1:0] w_addr_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          mem_fetch_o,
    output logic          mem_store_o,
    input  logic          mem_done_i,
    output logic          alu_add_o,
    output logic [DW-1:0] r1_o,
    output logic [DW-1:0] r2_o,
    output logic [DW-1:0] r3_o,
    output logic          busy_o,
    output logic          done_o
);

    ctl_t ctl;

    addseq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mem_done_i (mem_done_i),
        .ctl_o      (ctl)
    );

    addseq_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (ctl.capture),
        .mar_src_i (ctl.mar_src),
        .x_addr_i  (x_addr_i),
        .y_addr_i  (y_addr_i),
        .w_addr_i  (w_addr_i),
        .mar_o     (mem_addr_o)
    );

    addseq_regs #(.DW(DW)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .mdr_from_mem_i (ctl.mdr_from_mem),
        .mdr_from_sum_i (ctl.mdr_from_sum),
        .r1_load_i      (ctl.r1_load),
        .r2_load_i      (ctl.r2_load),
        .sum_load_i     (ctl.sum_load),
        .mem_rdata_i    (mem_rdata_i),
        .mdr_o          (mem_wdata_o),
        .r1_o           (r1_o),
        .r2_o           (r2_o),
        .r3_o           (r3_o)
    );

    assign mem_fetch_o = ctl.fetch;
    assign mem_store_o = ctl.store;
    assign alu_add_o   = ctl.sum_load;
    assign busy_o      = ctl.busy;
    assign done_o      = ctl.done;

endmodule

// File: rtl/mm_add_sequencer_chk.sv
`timescale 1ns/1ps
module mm_add_sequencer_chk #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_fetch_o,
    input logic          mem_store_o,
    input logic          mem_done_i,
    input logic          alu_add_o,
    input logic [DW-1:0] r1_o,
    input logic [DW-1:0] r2_o,
    input logic [DW-1:0] r3_o,
    input logic          busy_o,
    input logic          done_o
);

    // R10: one request kind at a time
    p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_fetch_o && mem_store_o));

    // R10: requests only during a run
    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fetch_o || mem_store_o) |-> busy_o);

    // R1: an idle sequencer issues no command
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_fetch_o || mem_store_o || alu_add_o));

    // R6: fetch held with a stable address until acknowledged
    p_fetch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fetch_o && !mem_done_i) |=> (mem_fetch_o && $stable(mem_addr_o)));

    // R6: store held with stable address and data until acknowledged
    p_store_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_store_o && !mem_done_i) |=>
            (mem_store_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R4: add command is a single-cycle pulse producing the wrapped sum
    p_sum_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alu_add_o |=> (!alu_add_o && (r3_o == DW'($past(r1_o) + $past(r2_o)))));

    // R9: done is one cycle and leaves the sequencer idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

endmodule

bind mm_add_sequencer mm_add_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_fetch_o (mem_fetch_o),
    .mem_store_o (mem_store_o),
    .mem_done_i  (mem_done_i),
    .alu_add_o   (alu_add_o),
    .r1_o        (r1_o),
    .r2_o        (r2_o),
    .r3_o        (r3_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/mm_add_sequencer_tb_top.sv
`timescale 1ns/1ps
module mm_add_sequencer_tb_top;

    localparam time CLK_PERIOD = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] x_addr_i = '0, y_addr_i = '0, w_addr_i = '0;
    logic [7:0] mem_addr_o, mem_wdata_o;
    logic [7:0] mem_rdata_i = 8'hA5;
    logic       mem_fetch_o, mem_store_o;
    logic       mem_done_i = 1'b0;
    logic       alu_add_o;
    logic [7:0] r1_o, r2_o, r3_o;
    logic       busy_o, done_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] mem [256];
    int         mem_lat = 1;
    int         wait_cnt = 0;
    int         acc_cnt = 0;
    logic [7:0] acc_addr [8];
    logic [7:0] acc_data [8];
    logic       acc_store [8];
    logic       mon_on = 1'b0;
    int         fetch_cyc = 0, store_cyc = 0, add_cyc = 0, both_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_add_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .x_addr_i(x_addr_i), .y_addr_i(y_addr_i), .w_addr_i(w_addr_i),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_fetch_o(mem_fetch_o),
        .mem_store_o(mem_store_o), .mem_done_i(mem_done_i),
        .alu_add_o(alu_add_o), .r1_o(r1_o), .r2_o(r2_o), .r3_o(r3_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory model and monitor, acting on falling edges
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (mem_fetch_o) fetch_cyc++;
                if (mem_store_o) store_cyc++;
                if (alu_add_o)   add_cyc++;
                if (mem_fetch_o && mem_store_o) both_cyc++;
            end
            if (mem_done_i) begin
                mem_done_i  = 1'b0;
                mem_rdata_i = 8'hA5;
                wait_cnt    = 0;
            end else if (mem_fetch_o || mem_store_o) begin
                wait_cnt++;
                if (wait_cnt >= mem_lat) begin
                    mem_done_i = 1'b1;
                    if (acc_cnt < 8) begin
                        acc_addr[acc_cnt]  = mem_addr_o;
                        acc_store[acc_cnt] = mem_store_o;
                        acc_data[acc_cnt]  = mem_store_o ? mem_wdata_o : mem[mem_addr_o];
                    end
                    acc_cnt++;
                    if (mem_store_o) mem[mem_addr_o] = mem_wdata_o;
                    else             mem_rdata_i = mem[mem_addr_o];
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // One complete run with all checks for R2..R10
    task automatic run_add(input string tag, input logic [7:0] xa, ya, wa,
                           input logic [7:0] vx, vy, input int lat, input int inject_at);
        logic [7:0] ex_x, ex_y, ex_sum;
        int n;
        mem[xa] = vx;
        mem[ya] = vy;
        ex_x   = mem[xa];
        ex_y   = mem[ya];
        ex_sum = ex_x + ex_y;
        mem_lat = lat;
        acc_cnt = 0;
        fetch_cyc = 0; store_cyc = 0; add_cyc = 0; both_cyc = 0;
        @(negedge clk);
        mon_on = 1'b1;
        x_addr_i = xa; y_addr_i = ya; w_addr_i = wa;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R7: scramble address inputs once the start has been taken
        x_addr_i = xa ^ 8'h5A; y_addr_i = ya ^ 8'h3C; w_addr_i = wa ^ 8'h99;
        n = 1;
        while (!done_o && n < 300) begin
            @(negedge clk);
            n++;
            if (n == inject_at) begin
                start_i = 1'b1;                        // R8: start while busy
                x_addr_i = xa ^ 8'h11; y_addr_i = ya ^ 8'h22; w_addr_i = wa ^ 8'h44;
            end
            if (n == inject_at + 1) start_i = 1'b0;
        end
        check("R6", {tag, " run length"}, n, 8 + 3 * lat);
        @(negedge clk);
        check("R9", {tag, " done one cycle"}, int'(done_o), 0);
        check("R9", {tag, " idle after done"}, int'(busy_o), 0);
        mon_on = 1'b0;
        check("R5", {tag, " access count"}, acc_cnt, 3);
        check("R2", {tag, " first access kind"}, int'(acc_store[0]), 0);
        check("R2", {tag, " first access addr"}, int'(acc_addr[0]), int'(xa));
        check("R3", {tag, " second access kind"}, int'(acc_store[1]), 0);
        check("R3", {tag, " second access addr"}, int'(acc_addr[1]), int'(ya));
        check("R5", {tag, " third access kind"}, int'(acc_store[2]), 1);
        check("R5", {tag, " store addr"}, int'(acc_addr[2]), int'(wa));
        check("R5", {tag, " store data"}, int'(acc_data[2]), int'(ex_sum));
        check("R5", {tag, " memory result"}, int'(mem[wa]), int'(ex_sum));
        check("R2", {tag, " r1"}, int'(r1_o), int'(ex_x));
        check("R3", {tag, " r2"}, int'(r2_o), int'(ex_y));
        check("R4", {tag, " r3 wrapped sum"}, int'(r3_o), int'(ex_sum));
        check("R4", {tag, " add pulses"}, add_cyc, 1);
        check("R6", {tag, " fetch held cycles"}, fetch_cyc, 2 * lat);
        check("R6", {tag, " store held cycles"}, store_cyc, lat);
        check("R10", {tag, " fetch+store overlap"}, both_cyc, 0);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "reset busy", int'(busy_o), 0);
        check("R1", "reset done", int'(done_o), 0);
        check("R1", "reset requests", int'(mem_fetch_o | mem_store_o | alu_add_o), 0);
        check("R1", "reset regs", int'(r1_o | r2_o | r3_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after release", int'(busy_o), 0);
    endtask

    task automatic t_basic();
        run_add("basic", 8'h00, 8'hFF, 8'h30, 8'd10, 8'd20, 1, 0);
    endtask

    task automatic t_wrap();
        run_add("wrap", 8'h12, 8'h34, 8'h56, 8'd200, 8'd100, 3, 0);
    endtask

    task automatic t_same_operand();
        run_add("same", 8'h40, 8'h40, 8'h41, 8'd77, 8'd77, 2, 0);
    endtask

    task automatic t_overwrite_x();
        run_add("overwrite", 8'h60, 8'h61, 8'h60, 8'd5, 8'd250, 1, 0);
    endtask

    task automatic t_busy_start();
        run_add("busystart", 8'h70, 8'h81, 8'h92, 8'd33, 8'd44, 2, 4);
        repeat (3) @(negedge clk);
        check("R8", "no second run", int'(busy_o), 0);
        check("R8", "no extra access", acc_cnt, 3);
    endtask

    task automatic t_reset_clears();
        run_add("prereset", 8'h05, 8'h06, 8'h07, 8'd9, 8'd8, 1, 0);
        @(negedge clk);
        x_addr_i = 8'h08; y_addr_i = 8'h09; w_addr_i = 8'h0A;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid-run reset r1", int'(r1_o), 0);
        check("R1", "mid-run reset r2", int'(r2_o), 0);
        check("R1", "mid-run reset r3", int'(r3_o), 0);
        check("R1", "mid-run reset busy", int'(busy_o), 0);
        rst_n = 1'b1;
        mem_done_i = 1'b0;
        @(negedge clk);
        run_add("postreset", 8'h0B, 8'h0C, 8'h0D, 8'd1, 8'd2, 1, 0);
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_wrap();
        t_same_operand();
        t_overwrite_x();
        t_busy_start();
        t_reset_clears();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule